// File: doc/BRIEF.md
# Chip bus last-value latch

This block remembers the most recent 16-bit word seen on a shared chip bus. The word can come from a graphics blitter channel, from an instruction-word fetch by the display-list coprocessor, or from a memory refresh slot, which drives all ones onto the bus. Ordinary processor accesses to chip memory have no port here, so they cannot touch the stored word.

The block also answers processor reads of the register space. A readable register returns its own contents. A read of a register that is write-only or absent has two effects. It starts a side write to that same register, and it returns a word that depends on the chipset generation and on the bus history. The older generation returns the bus residue from before the read, and that residue then takes the side-write value. The enhanced generation returns the side-write value and then resets the residue to all ones. When the processor is in compatible mode, the side-write value is its prefetch word. Otherwise it is all ones.

Top module: `bus_residue_latch`

## Requirements
- R1: After an active-low reset the stored word is 0xFFFF.
- R2: A blitter channel strobe loads that channel's data word at the next clock edge. Channel k is carried on bits k*16+15 down to k*16 of the flattened data port.
- R3: A coprocessor fetch strobe (first or second instruction word alike) loads the fetched word at the next clock edge.
- R4: A refresh slot loads 0xFFFF, and it takes priority over every other source in the same cycle.
- R5: When several DMA sources strobe in the same cycle, the lowest-numbered blitter channel wins. The coprocessor ranks below all blitter channels.
- R6: A DMA load takes priority over the side-write update in the same cycle.
- R7: A read of a non-readable address raises side_we_o in the same cycle, with side_addr_o equal to the read address. side_data_o is prefetch_i when compat_i is 1 and 0xFFFF otherwise.
- R8: On the older generation (gen_enh_i = 0), a non-readable read returns the stored word from before the read. Without a higher-priority source, the stored word then becomes side_data_o.
- R9: On the enhanced generation (gen_enh_i = 1), a non-readable read returns side_data_o. Without a higher-priority source, the stored word then becomes 0xFFFF.
- R10: Under the default map, word addresses 0 to 15 are readable. A read there returns reg_rdata_i, raises no side write and leaves the stored word unchanged.
- R11: With no read request, rd_data_o is 0 and side_we_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blt_vld_i | input | N_BLT | Per-channel blitter bus strobe |
| blt_data_i | input | N_BLT*16 | Blitter channel data words, flattened |
| cop_vld_i | input | 1 | Coprocessor instruction fetch strobe |
| cop_data_i | input | 16 | Fetched coprocessor word |
| refresh_i | input | 1 | Refresh slot in this cycle |
| gen_enh_i | input | 1 | 1 selects the enhanced generation |
| compat_i | input | 1 | Processor in compatible mode |
| prefetch_i | input | 16 | Processor prefetch word |
| rd_req_i | input | 1 | Processor register read |
| rd_addr_i | input | ADDR_W | Register word address |
| reg_rdata_i | input | 16 | Contents of the addressed readable register |
| rd_data_o | output | 16 | Read data returned to the processor |
| side_we_o | output | 1 | Side-effect write strobe |
| side_addr_o | output | ADDR_W | Side-effect write address |
| side_data_o | output | 16 | Side-effect write data |

## Verification
The bench goes after same-cycle collisions: refresh against DMA, several blitter channels together, the coprocessor against a blitter channel, and DMA against a side write. Each collision is then revealed by an older-generation non-readable read. A wrong priority shows up there as the losing agent's word or a stale 0xFFFF. Back-to-back non-readable reads on each generation expose a design that returns the post-read value on the older part, or one that forgets to clear to all ones on the enhanced part. Readable reads placed between them catch a latch that is wrongly disturbed or a side write that wrongly fires.

// File: rtl/bus_residue_pkg.sv
package bus_residue_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  typedef enum logic [1:0] {
    SRC_HOLD,
    SRC_REFRESH,
    SRC_DMA,
    SRC_SIDE
  } src_e;
endpackage

// File: rtl/brl_agent_pick.sv
module brl_agent_pick #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 16
) (
  input  logic [N-1:0]   vld_i,
  input  logic [N*W-1:0] data_i,
  output logic           any_o,
  output logic [W-1:0]   word_o
);
  // chain from highest index down so index 0 ends up winning
  logic [W-1:0] word_c [N+1];
  logic [N:0]   hit_c;

  assign word_c[N] = '0;
  assign hit_c[N]  = 1'b0;

  for (genvar k = N - 1; k >= 0; k--) begin : g_stage
    assign hit_c[k]  = vld_i[k] | hit_c[k+1];
    assign word_c[k] = vld_i[k] ? data_i[k*W +: W] : word_c[k+1];
  end

  assign any_o  = hit_c[0];
  assign word_o = word_c[0];
endmodule

// File: rtl/brl_reg_decode.sv
module brl_reg_decode #(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned N_REG = 1 << ADDR_W,
  parameter logic [N_REG-1:0] READ_MAP = {{(N_REG-16){1'b0}}, 16'hFFFF}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              readable_o
);
  assign readable_o = READ_MAP[addr_i];
endmodule

// File: rtl/brl_side_gen.sv
module brl_side_gen
  import bus_residue_pkg::*;
(
  input  logic              compat_i,
  input  logic [WORD_W-1:0] prefetch_i,
  output logic [WORD_W-1:0] side_o
);
  assign side_o = compat_i ? prefetch_i : ALL_ONES;
endmodule

// File: rtl/bus_residue_latch.sv
module bus_residue_latch
  import bus_residue_pkg::*;
#(
  parameter int unsigned N_BLT  = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned N_REG = 1 << ADDR_W,
  parameter logic [N_REG-1:0] READ_MAP = {{(N_REG-16){1'b0}}, 16'hFFFF}
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_BLT-1:0]        blt_vld_i,
  input  logic [N_BLT*WORD_W-1:0] blt_data_i,
  input  logic                    cop_vld_i,
  input  logic [WORD_W-1:0]       cop_data_i,
  input  logic                    refresh_i,
  input  logic                    gen_enh_i,
  input  logic                    compat_i,
  input  logic [WORD_W-1:0]       prefetch_i,
  input  logic                    rd_req_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic [WORD_W-1:0]       reg_rdata_i,
  output logic [WORD_W-1:0]       rd_data_o,
  output logic                    side_we_o,
  output logic [ADDR_W-1:0]       side_addr_o,
  output logic [WORD_W-1:0]       side_data_o
);
  localparam int unsigned N_AG = N_BLT + 1;

  logic              dma_any;
  logic [WORD_W-1:0] dma_word;
  logic              readable;
  logic [WORD_W-1:0] side_val;
  logic              side_hit;
  logic [WORD_W-1:0] latch_q, latch_d;
  src_e              src_sel;

  // coprocessor sits above the blitter channels -> lowest priority
  brl_agent_pick #(.N(N_AG), .W(WORD_W)) u_pick (
    .vld_i  ({cop_vld_i, blt_vld_i}),
    .data_i ({cop_data_i, blt_data_i}),
    .any_o  (dma_any),
    .word_o (dma_word)
  );

  brl_reg_decode #(.ADDR_W(ADDR_W), .READ_MAP(READ_MAP)) u_dec (
    .addr_i     (rd_addr_i),
    .readable_o (readable)
  );

  brl_side_gen u_side (
    .compat_i   (compat_i),
    .prefetch_i (prefetch_i),
    .side_o     (side_val)
  );

  assign side_hit = rd_req_i & ~readable;

  always_comb begin
    if (refresh_i)     src_sel = SRC_REFRESH;
    else if (dma_any)  src_sel = SRC_DMA;
    else if (side_hit) src_sel = SRC_SIDE;
    else               src_sel = SRC_HOLD;
  end

  always_comb begin
    unique case (src_sel)
      SRC_REFRESH: latch_d = ALL_ONES;
      SRC_DMA:     latch_d = dma_word;
      SRC_SIDE:    latch_d = gen_enh_i ? ALL_ONES : side_val;
      default:     latch_d = latch_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= ALL_ONES;
    else         latch_q <= latch_d;
  end

  always_comb begin
    if (!rd_req_i)     rd_data_o = '0;
    else if (readable) rd_data_o = reg_rdata_i;
    else if (gen_enh_i) rd_data_o = side_val;
    else               rd_data_o = latch_q;
  end

  assign side_we_o   = side_hit;
  assign side_addr_o = rd_addr_i;
  assign side_data_o = side_val;
endmodule

// File: rtl/bus_residue_latch_chk.sv
module bus_residue_latch_chk #(
  parameter int unsigned N_BLT  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_BLT-1:0]     blt_vld_i,
  input logic                 cop_vld_i,
  input logic [15:0]          cop_data_i,
  input logic                 refresh_i,
  input logic                 gen_enh_i,
  input logic                 rd_req_i,
  input logic [15:0]          rd_data_o,
  input logic                 side_we_o,
  input logic [15:0]          side_data_o,
  input logic [15:0]          latch_q
);
  logic quiet;
  assign quiet = !refresh_i && !cop_vld_i && (blt_vld_i == '0);

  a_r4_refresh_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> latch_q == 16'hFFFF);

  a_r3_cop_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_vld_i && !refresh_i && blt_vld_i == '0) |=> latch_q == $past(cop_data_i));

  a_r8_old_prior_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (side_we_o && !gen_enh_i) |-> rd_data_o == latch_q);

  a_r8_old_takes_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (side_we_o && !gen_enh_i && quiet) |=> latch_q == $past(side_data_o));

  a_r9_enh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (side_we_o && gen_enh_i && quiet) |=> latch_q == 16'hFFFF);

  a_r11_idle_no_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |-> (!side_we_o && rd_data_o == 16'h0000));
endmodule

bind bus_residue_latch bus_residue_latch_chk #(.N_BLT(N_BLT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blt_vld_i   (blt_vld_i),
  .cop_vld_i   (cop_vld_i),
  .cop_data_i  (cop_data_i),
  .refresh_i   (refresh_i),
  .gen_enh_i   (gen_enh_i),
  .rd_req_i    (rd_req_i),
  .rd_data_o   (rd_data_o),
  .side_we_o   (side_we_o),
  .side_data_o (side_data_o),
  .latch_q     (latch_q)
);

// File: tb/bus_residue_latch_bench.sv
module bus_residue_latch_bench;
  localparam int unsigned NB = 4;
  localparam int unsigned AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NB-1:0] blt_vld_i = '0;
  logic [NB*16-1:0] blt_data_i = '0;
  logic          cop_vld_i = 1'b0;
  logic [15:0]   cop_data_i = '0;
  logic          refresh_i = 1'b0;
  logic          gen_enh_i = 1'b0;
  logic          compat_i = 1'b0;
  logic [15:0]   prefetch_i = '0;
  logic          rd_req_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [15:0]   reg_rdata_i = '0;
  logic [15:0]   rd_data_o;
  logic          side_we_o;
  logic [AW-1:0] side_addr_o;
  logic [15:0]   side_data_o;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic [15:0] m_latch = 16'hFFFF;

  always #5 clk_i = ~clk_i;

  bus_residue_latch #(.N_BLT(NB), .ADDR_W(AW)) u_bus_residue_latch (.*);

  function automatic logic is_readable(input logic [AW-1:0] a);
    return a < 16;
  endfunction

  function automatic logic [15:0] exp_side();
    return compat_i ? prefetch_i : 16'hFFFF;
  endfunction

  function automatic logic [15:0] exp_rd();
    if (!rd_req_i) return 16'h0000;
    if (is_readable(rd_addr_i)) return reg_rdata_i;
    if (gen_enh_i) return exp_side();
    return m_latch;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // settle, compare, then advance the model by what the coming edge captures
  task automatic step(input string note);
    string t;
    logic  hit;
    #1;
    if (!rd_req_i) t = "R11";
    else if (is_readable(rd_addr_i)) t = "R10";
    else if (gen_enh_i) t = "R9";
    else t = "R8";
    check({note, " ", t, " rd_data"}, {16'h0, rd_data_o}, {16'h0, exp_rd()});
    hit = rd_req_i && !is_readable(rd_addr_i);
    check({note, " R7 side_we"}, {31'h0, side_we_o}, {31'h0, hit});
    if (hit) begin
      check({note, " R7 side_addr"}, {24'h0, side_addr_o}, {24'h0, rd_addr_i});
      check({note, " R7 side_data"}, {16'h0, side_data_o}, {16'h0, exp_side()});
    end
    if (refresh_i) m_latch = 16'hFFFF;
    else if (blt_vld_i != '0) begin
      for (int k = NB - 1; k >= 0; k--)
        if (blt_vld_i[k]) m_latch = blt_data_i[k*16 +: 16];
    end else if (cop_vld_i) m_latch = cop_data_i;
    else if (hit) m_latch = gen_enh_i ? 16'hFFFF : exp_side();
  endtask

  task automatic idle();
    blt_vld_i = '0; cop_vld_i = 1'b0; refresh_i = 1'b0; rd_req_i = 1'b0;
  endtask

  task automatic probe(input string note);
    // older-generation non-readable read exposes the stored word
    @(negedge clk_i);
    idle(); gen_enh_i = 1'b0; compat_i = 1'b0;
    rd_req_i = 1'b1; rd_addr_i = 8'h80;
    step(note);
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    probe("R1 reset value");

    // R2 single blitter channel
    @(negedge clk_i); idle(); blt_vld_i = 4'b0100; blt_data_i[2*16 +: 16] = 16'h1357; step("R2 load");
    probe("R2 observe");

    // R3 coprocessor fetch
    @(negedge clk_i); idle(); cop_vld_i = 1'b1; cop_data_i = 16'h2468; step("R3 load");
    probe("R3 observe");

    // R4 refresh beats DMA
    @(negedge clk_i); idle(); refresh_i = 1'b1; blt_vld_i = 4'b1111; cop_vld_i = 1'b1; step("R4 collide");
    probe("R4 observe");

    // R5 several blitter channels plus coprocessor
    @(negedge clk_i); idle();
    blt_data_i = 64'hDDDD_CCCC_BBBB_AAAA; blt_vld_i = 4'b1010; cop_vld_i = 1'b1; step("R5 collide");
    probe("R5 observe");
    @(negedge clk_i); idle(); blt_vld_i = 4'b0000; cop_vld_i = 1'b1; cop_data_i = 16'h0F0F; step("R5 cop only");
    @(negedge clk_i); idle(); blt_vld_i = 4'b1000; cop_vld_i = 1'b1; step("R5 cop vs ch3");
    probe("R5 observe2");

    // R6 DMA beats side write
    @(negedge clk_i); idle(); blt_vld_i = 4'b0001; gen_enh_i = 1'b1;
    rd_req_i = 1'b1; rd_addr_i = 8'h40; step("R6 collide");
    probe("R6 observe");

    // R8 back-to-back older-generation reads with compat prefetch
    @(negedge clk_i); idle(); compat_i = 1'b1; prefetch_i = 16'h4E71;
    rd_req_i = 1'b1; rd_addr_i = 8'h55; step("R8 first");
    @(negedge clk_i); prefetch_i = 16'h1111; step("R8 second");

    // R10 readable read leaves the word alone
    @(negedge clk_i); idle(); rd_req_i = 1'b1; rd_addr_i = 8'h0F; reg_rdata_i = 16'hBEEF; step("R10 read");
    probe("R10 observe");

    // R9 enhanced read returns side value then clears
    @(negedge clk_i); idle(); gen_enh_i = 1'b1; compat_i = 1'b1; prefetch_i = 16'h5A5A;
    rd_req_i = 1'b1; rd_addr_i = 8'hFF; step("R9 read");
    probe("R9 observe");

    // R11 idle
    @(negedge clk_i); idle(); step("R11 idle");

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      blt_vld_i   = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
      blt_data_i  = {$urandom, $urandom};
      cop_vld_i   = ($urandom % 5 == 0);
      cop_data_i  = 16'($urandom);
      refresh_i   = ($urandom % 8 == 0);
      gen_enh_i   = 1'($urandom);
      compat_i    = 1'($urandom);
      prefetch_i  = 16'($urandom);
      rd_req_i    = ($urandom % 2 == 0);
      rd_addr_i   = ($urandom % 3 == 0) ? 8'($urandom % 16) : 8'($urandom);
      reg_rdata_i = 16'($urandom);
      step("rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule